// File: doc/BRIEF.md
# Bit-Serial Four-Bit Adder

This block adds two 4-bit unsigned operands one bit per clock, least significant bit first. The datapath has three parts: one single-bit full adder, two 4-bit right-shifting registers, and one flip-flop that holds the carry between steps. The first operand register (X) also serves as the result register. On each step, the new sum bit enters X at its top, so that after four steps X contains the sum. The carry flip-flop then holds the carry out of bit 3.

To use the block, pulse `load` with both operands on `op_a` and `op_b`. Then assert `shift_en` for four cycles. These cycles need not be consecutive. Once the fourth step has been taken, `done` is high. It stays high, and the block ignores further shift requests, until the next load. The full-adder sum bit for the step about to happen is visible on `sum_bit` at all times.

Top module: `sa_serial_adder`

## Requirements
- R1: After a synchronous active-high reset, `x_q`, `y_q`, `carry_q` and `done` are all 0.
- R2: A cycle with `load` high sets `x_q`=`op_a`, `y_q`=`op_b`, `carry_q`=0 and `done`=0 on the next edge. Load takes priority over `shift_en`.
- R3: `sum_bit` equals `x_q[0]` XOR `y_q[0]` XOR `carry_q` at every moment.
- R4: On an active step (`shift_en`=1, `load`=0, `done`=0), X moves right by one bit and the sum bit enters `x_q[3]`.
- R5: On an active step, Y moves right by one bit and a 0 enters `y_q[3]`.
- R6: On an active step, `carry_q` takes the carry-out of the full adder, which is the majority of `x_q[0]`, `y_q[0]` and `carry_q`.
- R7: With `load` and `shift_en` both low, `x_q`, `y_q`, `carry_q` and `done` keep their values.
- R8: `done` rises on the edge of the fourth active step after a load. At that point `x_q` = (A+B) mod 16, `carry_q` = bit 4 of A+B, and `y_q` = 0. For example, A=1010 and B=0110 give X=0000 and carry 1.
- R9: While `done` is high, `shift_en` has no effect. `x_q`, `y_q`, `carry_q` and `done` stay unchanged until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel load strobe for both operands |
| op_a | input | 4 | First operand, loaded into X |
| op_b | input | 4 | Second operand, loaded into Y |
| shift_en | input | 1 | Request one serial add step |
| x_q | output | 4 | Register X (operand A, then the sum) |
| y_q | output | 4 | Register Y (operand B, drained to 0) |
| carry_q | output | 1 | Carry flip-flop |
| sum_bit | output | 1 | Current full-adder sum output |
| done | output | 1 | Four steps have completed since the last load |

## Verification
The assertions check the per-cycle rules on every edge:
- the right shift of X and Y, with zero fill into Y;
- the carry capture;
- holding all state when idle or finished;
- the load values;
- the combinational sum bit.

Only the bench scenarios can show the arithmetic result, because it spans four steps with gaps between them. These scenarios also cover the exact step on which `done` rises and the stated 1010 + 0110 example. The bench does this by comparing a cycle-level model and the final sum against integer addition over random operands and random shift patterns.

// File: rtl/sa_pkg.sv
package sa_pkg;
    localparam int SA_WIDTH = 4;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_res_t;

    typedef struct packed {
        logic a;
        logic b;
        logic cin;
    } fa_in_t;

    function automatic fa_res_t fa_eval(fa_in_t i);
        fa_res_t r;
        r.sum  = i.a ^ i.b ^ i.cin;
        r.cout = (i.a & i.b) | (i.a & i.cin) | (i.b & i.cin);
        return r;
    endfunction
endpackage

// File: rtl/sa_full_adder.sv
module sa_full_adder
    import sa_pkg::*;
(
    input  fa_in_t  fa_in,
    output fa_res_t fa_out
);
    assign fa_out = fa_eval(fa_in);

    always_comb begin
        // p_sum_parity_r3
        assert ($countones({fa_in.a, fa_in.b, fa_in.cin}) % 2 == int'(fa_out.sum))
            else $error("p_sum_parity_r3");
    end
endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         step,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (ld)   q <= ld_val;
        else if (step) q <= {ser_in, q[W-1:1]};
    end

    p_shift_right_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !ld) |=> (q[W-1:0] == {$past(ser_in), $past(q[W-1:1])}));

    p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(ld_val)));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!ld && !step) |=> $stable(q));
endmodule

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  logic shift_req,
    input  logic cout,
    output logic step,
    output logic carry_q,
    output logic done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;

    assign step = shift_req && !ld && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            carry_q <= 1'b0;
            done    <= 1'b0;
        end else if (ld) begin
            cnt     <= '0;
            carry_q <= 1'b0;
            done    <= 1'b0;
        end else if (step) begin
            carry_q <= cout;
            cnt     <= cnt + 1'b1;
            if (cnt == LAST) done <= 1'b1;
        end
    end

    p_carry_capture_r6: assert property (@(posedge clk) disable iff (rst)
        step |=> (carry_q == $past(cout)));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !ld) |=> (done && $stable(carry_q)));

    p_load_clear_r2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (!done && !carry_q));

    p_done_count_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cnt == CW'(W)));
endmodule

// File: rtl/sa_serial_adder.sv
module sa_serial_adder
    import sa_pkg::*;
#(
    parameter int WIDTH = SA_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             shift_en,
    output logic [WIDTH-1:0] x_q,
    output logic [WIDTH-1:0] y_q,
    output logic             carry_q,
    output logic             sum_bit,
    output logic             done
);
    fa_in_t  fa_i;
    fa_res_t fa_o;
    logic    step;

    assign fa_i.a   = x_q[0];
    assign fa_i.b   = y_q[0];
    assign fa_i.cin = carry_q;
    assign sum_bit  = fa_o.sum;

    sa_full_adder u_fa (
        .fa_in  (fa_i),
        .fa_out (fa_o)
    );

    sa_seq_ctrl #(.W(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ld        (load),
        .shift_req (shift_en),
        .cout      (fa_o.cout),
        .step      (step),
        .carry_q   (carry_q),
        .done      (done)
    );

    sa_shift_reg #(.W(WIDTH)) u_xreg (
        .clk    (clk),
        .rst    (rst),
        .ld     (load),
        .ld_val (op_a),
        .step   (step),
        .ser_in (fa_o.sum),
        .q      (x_q)
    );

    sa_shift_reg #(.W(WIDTH)) u_yreg (
        .clk    (clk),
        .rst    (rst),
        .ld     (load),
        .ld_val (op_b),
        .step   (step),
        .ser_in (1'b0),
        .q      (y_q)
    );

    p_y_zero_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load && !done) |=> (y_q[WIDTH-1] == 1'b0));

    p_finished_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> ($stable(x_q) && $stable(y_q)));

    p_y_empty_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (y_q == '0));
endmodule

// File: tb/test_sa_serial_adder.sv
module test_sa_serial_adder;
    localparam int  W      = 4;
    localparam time PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst, load, shift_en;
    logic [W-1:0] op_a, op_b;
    logic [W-1:0] x_q, y_q;
    logic         carry_q, sum_bit, done;

    int n_vec = 0;
    int n_bad = 0;

    logic [W-1:0] mx, my;
    logic         mc, md;
    int           msteps;

    always #(PERIOD/2) clk = ~clk;

    sa_serial_adder #(.WIDTH(W)) i_sa_serial_adder (
        .clk(clk), .rst(rst), .load(load), .op_a(op_a), .op_b(op_b),
        .shift_en(shift_en), .x_q(x_q), .y_q(y_q), .carry_q(carry_q),
        .sum_bit(sum_bit), .done(done)
    );

    function automatic logic fa_sum(logic a, logic b, logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic fa_carry(logic a, logic b, logic c);
        return (int'(a) + int'(b) + int'(c)) >= 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(x_q == mx, {req, " x"}, x_q, mx);
        chk(y_q == my, {req, " y"}, y_q, my);
        chk(carry_q == mc, {req, " carry"}, carry_q, mc);
        chk(done == md, {req, " done"}, done, md);
        chk(sum_bit == fa_sum(mx[0], my[0], mc), "R3 sum_bit", sum_bit,
            fa_sum(mx[0], my[0], mc));
    endtask

    // drive at negedge, update model, compare at next negedge
    task automatic cyc(input logic ld, input logic sh, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string req);
        logic s, c;
        load = ld; shift_en = sh; op_a = a; op_b = b;
        if (ld) begin
            mx = a; my = b; mc = 1'b0; md = 1'b0; msteps = 0;
        end else if (sh && !md) begin
            s = fa_sum(mx[0], my[0], mc);
            c = fa_carry(mx[0], my[0], mc);
            mx = {s, mx[W-1:1]};
            my = {1'b0, my[W-1:1]};
            mc = c;
            msteps++;
            if (msteps == W) md = 1'b1;
        end
        @(negedge clk);
        check_all(req);
    endtask

    task automatic full_add(input logic [W-1:0] a, input logic [W-1:0] b,
                            input bit gaps, input string req);
        int sum;
        cyc(1'b1, 1'b1, a, b, "R2 load");
        for (int k = 0; k < W; k++) begin
            if (gaps && ($urandom % 2)) cyc(1'b0, 1'b0, a, b, "R7 idle");
            cyc(1'b0, 1'b1, a, b, "R4 R5 R6 step");
        end
        sum = int'(a) + int'(b);
        chk(x_q == W'(sum), {req, " R8 final x"}, x_q, sum % 16);
        chk(carry_q == sum[W], {req, " R8 final carry"}, carry_q, sum[W]);
        chk(done == 1'b1, {req, " R8 done"}, done, 1);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; load = 1'b0; shift_en = 1'b0; op_a = '0; op_b = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mx = '0; my = '0; mc = 1'b0; md = 1'b0; msteps = 0;
        check_all("R1 reset");

        // stated example
        full_add(4'b1010, 4'b0110, 1'b0, "R8 example");
        chk(x_q == 4'b0000 && y_q == 4'b0000 && carry_q,
            "R8 example state", {x_q, y_q, 3'b0, carry_q}, 1);

        // R9: extra shifts ignored after done
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 4'h3, 4'h5, "R9 ignored");

        // corner cases
        full_add(4'hF, 4'hF, 1'b0, "max");
        full_add(4'h0, 4'h0, 1'b1, "zero");
        full_add(4'hF, 4'h1, 1'b1, "ripple");

        // R2 load in mid-addition wins over shift
        cyc(1'b1, 1'b0, 4'h7, 4'h9, "R2 load");
        cyc(1'b0, 1'b1, 4'h7, 4'h9, "R4 step");
        cyc(1'b1, 1'b1, 4'h2, 4'hC, "R2 reload priority");

        // random
        for (int t = 0; t < 60; t++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = W'($urandom);
            full_add(a, b, 1'b1, "random");
            if ($urandom % 2) cyc(1'b0, 1'b1, a, b, "R9 random ignored");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule